// File: doc/BRIEF.md
# Paged Program Sequencer

This unit keeps the program counter of a small controller whose instruction memory holds 4096 words. The current counter value is the fetch address presented to the instruction memory. On every clock edge the counter takes its next value from a 3-bit operation code. The counter can advance by one. It can load a target made from a 2-bit page number and a 10-bit offset within the page, or take the interrupt vector. It can also restore an address held in a small return stack.

Calls and interrupt entry save the address of the following instruction on an eight-entry circular stack. Plain returns, literal returns and returns from interrupt all restore the newest saved address. A return from interrupt also raises a one-cycle strobe, which outside logic uses to re-enable interrupts. The unit does not decode instructions: the caller maps each instruction onto one of the operation codes.

Top module: `prog_seq`

## Requirements
- R1: While reset is held, the fetch address is 0x000 and the interrupt-return strobe is low. Reset takes effect asynchronously, and the counter leaves 0x000 only after reset has been released for two clock edges.
- R2: Operation code 0 (advance) loads the fetch address plus one, wrapping from 0xFFF to 0x000 and crossing page boundaries without special handling.
- R3: Operation code 1 (jump) loads {page, offset}, with the page in bits 11:10 and the offset in bits 9:0, and leaves the return stack unchanged.
- R4: Operation code 2 (call) loads {page, offset} and saves the fetch address plus one on the return stack.
- R5: Operation code 3 (return, covering both plain return and return with literal) loads the newest saved address and removes it, so returns come back in last-in first-out order.
- R6: Operation code 4 (return from interrupt) behaves like code 3. In addition, the strobe is high for exactly the one cycle that follows that edge.
- R7: Operation code 5 (interrupt entry) loads 0x008 and saves the fetch address plus one, in the same way as a call.
- R8: The stack holds eight entries and wraps around. A ninth save without a matching return replaces the oldest entry. A return past the oldest entry reads the slot that comes next in ring order, and no error is reported.
- R9: Operation codes 6 and 7 behave as advance and leave the stack unchanged.
- R10: The page field selects each of the four 1024-word pages: 0x000, 0x400, 0x800 and 0xC00 are the page bases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code for this cycle |
| tgt_off_i | input | 10 | Offset within the page for jump and call |
| page_sel_i | input | 2 | Page number for jump and call |
| fetch_addr_o | output | 12 | Current program counter / fetch address |
| reti_pulse_o | output | 1 | One-cycle strobe after a return from interrupt |

## Verification
The bench builds the unit with its default parameters: a 12-bit counter, a 2-bit page field and an eight-entry stack. With these settings the top address 0xFFF and its wrap to zero can be reached directly with a jump. Nine nested calls are enough to overwrite the oldest stack slot and to read it back a second time. Each of the four page bases is reached, and the unit is reset while it is running.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    OP_ADV  = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_INTR = 3'd5
  } seq_op_e;
endpackage

// File: rtl/pcseq_rst_sync.sv
module pcseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0]            sp_q, sp_d;
  logic [PTR_W-1:0]            top_idx;
  logic [DEPTH-1:0]            wr_en;
  logic [DEPTH-1:0][WIDTH-1:0] slots;

  // ring pointer: points at the next free slot
  always_comb begin
    sp_d = sp_q;
    if (push_i)     sp_d = sp_q + PTR_W'(1);
    else if (pop_i) sp_d = sp_q - PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  assign top_idx = sp_q - PTR_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WIDTH-1:0] ent_q;
    assign wr_en[g] = push_i && (sp_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en[g]) ent_q <= push_data_i;
    end
    assign slots[g] = ent_q;
  end

  assign top_o = slots[top_idx];
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter int              PAGE_W = 2,
  parameter logic [ADDR_W-1:0] INT_VEC = 12'h008
) (
  input  logic [2:0]               op_i,
  input  logic [ADDR_W-PAGE_W-1:0] off_i,
  input  logic [PAGE_W-1:0]        page_i,
  input  logic [ADDR_W-1:0]        pc_i,
  input  logic [ADDR_W-1:0]        stack_top_i,
  output logic [ADDR_W-1:0]        pc_next_o,
  output logic [ADDR_W-1:0]        link_o,
  output logic                     push_o,
  output logic                     pop_o,
  output logic                     reti_o
);
  seq_op_e             op;
  logic [ADDR_W-1:0]   paged_tgt;

  assign op        = seq_op_e'(op_i);
  assign link_o    = pc_i + ADDR_W'(1);
  assign paged_tgt = {page_i, off_i};

  always_comb begin
    pc_next_o = link_o;
    push_o    = 1'b0;
    pop_o     = 1'b0;
    reti_o    = 1'b0;
    case (op)
      OP_JMP:  pc_next_o = paged_tgt;
      OP_CALL: begin
        pc_next_o = paged_tgt;
        push_o    = 1'b1;
      end
      OP_RET: begin
        pc_next_o = stack_top_i;
        pop_o     = 1'b1;
      end
      OP_RETI: begin
        pc_next_o = stack_top_i;
        pop_o     = 1'b1;
        reti_o    = 1'b1;
      end
      OP_INTR: begin
        pc_next_o = INT_VEC;
        push_o    = 1'b1;
      end
      default: pc_next_o = link_o;
    endcase
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int                ADDR_W      = 12,
  parameter int                PAGE_W      = 2,
  parameter int                STACK_DEPTH = 8,
  parameter logic [ADDR_W-1:0] INT_VEC     = 12'h008
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               op_i,
  input  logic [ADDR_W-PAGE_W-1:0] tgt_off_i,
  input  logic [PAGE_W-1:0]        page_sel_i,
  output logic [ADDR_W-1:0]        fetch_addr_o,
  output logic                     reti_pulse_o
);
  logic              core_rst_n;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] link, stack_top;
  logic              push, pop, reti_d, reti_q;

  pcseq_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_core_n(core_rst_n)
  );

  pcseq_next #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .INT_VEC(INT_VEC)
  ) u_next (
    .op_i       (op_i),
    .off_i      (tgt_off_i),
    .page_i     (page_sel_i),
    .pc_i       (pc_q),
    .stack_top_i(stack_top),
    .pc_next_o  (pc_d),
    .link_o     (link),
    .push_o     (push),
    .pop_o      (pop),
    .reti_o     (reti_d)
  );

  pcseq_stack #(
    .WIDTH(ADDR_W),
    .DEPTH(STACK_DEPTH)
  ) u_stack (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .push_i     (push),
    .pop_i      (pop),
    .push_data_i(link),
    .top_o      (stack_top)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q   <= '0;
      reti_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      reti_q <= reti_d;
    end
  end

  assign fetch_addr_o = pc_q;
  assign reti_pulse_o = reti_q;
endmodule

// File: rtl/prog_seq_checker.sv
module prog_seq_checker
  import pcseq_pkg::*;
#(
  parameter int                ADDR_W  = 12,
  parameter int                PAGE_W  = 2,
  parameter logic [ADDR_W-1:0] INT_VEC = 12'h008
) (
  input logic                     clk,
  input logic                     core_rst_n,
  input logic [2:0]               op_i,
  input logic [ADDR_W-PAGE_W-1:0] tgt_off_i,
  input logic [PAGE_W-1:0]        page_sel_i,
  input logic [ADDR_W-1:0]        fetch_addr_o,
  input logic                     reti_pulse_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    !core_rst_n |-> (fetch_addr_o == '0 && !reti_pulse_o));

  a_r2_advance: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_i == OP_ADV) |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1));

  a_r3_jump: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_i == OP_JMP) |=> fetch_addr_o == {$past(page_sel_i), $past(tgt_off_i)});

  a_r4_call: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_i == OP_CALL) |=> fetch_addr_o == {$past(page_sel_i), $past(tgt_off_i)});

  a_r6_pulse_follows: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_i == OP_RETI) |=> reti_pulse_o);

  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!core_rst_n)
    reti_pulse_o |-> $past(op_i) == OP_RETI);

  a_r7_vector: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_i == OP_INTR) |=> fetch_addr_o == INT_VEC);

  a_r9_spare_codes: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_i > 3'd5) |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1));
endmodule

bind prog_seq prog_seq_checker #(
  .ADDR_W (ADDR_W),
  .PAGE_W (PAGE_W),
  .INT_VEC(INT_VEC)
) u_chk (
  .clk         (clk),
  .core_rst_n  (core_rst_n),
  .op_i        (op_i),
  .tgt_off_i   (tgt_off_i),
  .page_sel_i  (page_sel_i),
  .fetch_addr_o(fetch_addr_o),
  .reti_pulse_o(reti_pulse_o)
);

// File: tb/prog_seq_bench.sv
module prog_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [9:0]  off = '0;
  logic [1:0]  page = '0;
  logic [11:0] fetch;
  logic        pulse;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  prog_seq u_prog_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .tgt_off_i   (off),
    .page_sel_i  (page),
    .fetch_addr_o(fetch),
    .reti_pulse_o(pulse)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  // drive one operation on a falling edge; result is sampled on the next falling edge
  task automatic step(input logic [2:0] o, input logic [1:0] p, input logic [9:0] f);
    op = o; page = p; off = f;
    @(negedge clk);
    op = 3'd0;
  endtask

  task automatic go(input logic [11:0] a);
    step(3'd1, a[11:10], a[9:0]);
  endtask

  task automatic settle;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", fetch, 12'h000);
    chk("R1 strobe in reset", {11'd0, pulse}, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 held one edge after release", fetch, 12'h000);
    repeat (2) @(negedge clk);
    chk("R1 counting after sync", fetch, 12'h001);
  endtask

  task automatic t_advance;
    go(12'h7FE);
    chk("R3 jump page1", fetch, 12'h7FE);
    step(3'd0, 2'd0, 10'd0);
    chk("R2 advance", fetch, 12'h7FF);
    step(3'd0, 2'd0, 10'd0);
    chk("R2 page crossing", fetch, 12'h800);
    go(12'hFFF);
    step(3'd0, 2'd0, 10'd0);
    chk("R2 wrap to zero", fetch, 12'h000);
  endtask

  task automatic t_pages;
    for (int p = 0; p < 4; p++) begin
      step(3'd1, 2'(p), 10'h155);
      chk("R10 page base", fetch, 12'(p * 1024 + 12'h155));
    end
  endtask

  task automatic t_call_ret;
    go(12'h100);
    step(3'd2, 2'd2, 10'h020);
    chk("R4 call target", fetch, 12'h820);
    go(12'h3AA);
    step(3'd2, 2'd1, 10'h056);
    chk("R4 second call", fetch, 12'h456);
    step(3'd3, 2'd0, 10'd0);
    chk("R5 inner return", fetch, 12'h3AB);
    step(3'd3, 2'd0, 10'd0);
    chk("R3 R5 outer return, jump saved nothing", fetch, 12'h101);
  endtask

  task automatic t_irq;
    go(12'h200);
    step(3'd5, 2'd3, 10'h3FF);
    chk("R7 vector", fetch, 12'h008);
    chk("R6 no strobe on entry", {11'd0, pulse}, 12'h000);
    step(3'd0, 2'd0, 10'd0);
    chk("R2 in handler", fetch, 12'h009);
    step(3'd4, 2'd0, 10'd0);
    chk("R6 R7 reti return", fetch, 12'h201);
    chk("R6 strobe high", {11'd0, pulse}, 12'h001);
    step(3'd0, 2'd0, 10'd0);
    chk("R6 strobe one cycle", {11'd0, pulse}, 12'h000);
    chk("R6 advance after", fetch, 12'h202);
  endtask

  task automatic t_spare;
    go(12'h050);
    step(3'd2, 2'd0, 10'h300);
    step(3'd6, 2'd1, 10'h111);
    chk("R9 code 6 advances", fetch, 12'h301);
    step(3'd7, 2'd2, 10'h222);
    chk("R9 code 7 advances", fetch, 12'h302);
    step(3'd3, 2'd0, 10'd0);
    chk("R9 stack untouched", fetch, 12'h051);
  endtask

  task automatic t_wrap;
    for (int i = 1; i <= 9; i++) begin
      go(12'(12'h300 + i * 16));
      step(3'd2, 2'd0, 10'h000);
    end
    for (int i = 9; i >= 2; i--) begin
      step(3'd3, 2'd0, 10'd0);
      chk("R8 ring pop order", fetch, 12'(12'h300 + i * 16 + 1));
    end
    step(3'd3, 2'd0, 10'd0);
    chk("R8 overwritten oldest slot", fetch, 12'h391);
  endtask

  task automatic t_midreset;
    go(12'hABC);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async clear", fetch, 12'h000);
    chk("R1 async strobe low", {11'd0, pulse}, 12'h000);
    settle();
    go(12'h444);
    chk("R1 alive after reset", fetch, 12'h444);
  endtask

  initial begin
    t_reset();
    t_advance();
    t_pages();
    t_call_ret();
    t_irq();
    t_spare();
    t_wrap();
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule